// File: doc/BRIEF.md
# Three-Phase Voltage Sag Status Monitor

The monitor takes one magnitude sample per phase (A, B, C) on every processing pass, marked by a sample-valid strobe. Each phase has its own run counter of consecutive samples that fall strictly below a shared threshold. When a run reaches the programmed length, that phase's sag flag rises. The first sample at or above the threshold clears the flag and restarts the run at once.

Once per pass the three flags and the level of a fundamental-frequency square wave are packed into a 32-bit status word. A host reads that word when the one-cycle done pulse appears. The word always describes the pass that has just completed, and it holds unchanged until the next strobe.

Top module: `sag_status_mon`

## Requirements
- R1: A phase flag becomes 1 on the pass where that phase has had exactly `sag_len` consecutive samples strictly below `thr`, not on an earlier pass. It stays 1 on every further low sample, because the run counter saturates at the limit.
- R2: A sample equal to or above `thr` clears that phase's flag on that same pass. A flag that is already 0 stays 0.
- R3: A sample at or above `thr` restarts the run, so a later run needs `sag_len` fresh low samples before the flag sets. The other phases are not affected.
- R4: Status bit 0 is the phase A flag, bit 1 the phase B flag, bit 2 the phase C flag and bit 3 the F0 level. Bits 31:4 are always 0.
- R5: Status bit 3 equals the value `f0_lvl` had in the cycle of the sample strobe.
- R6: The status word changes only in the cycle after a sample strobe. In every other cycle it holds its value.
- R7: A `sag_len` of 0 behaves as 1, so a single low sample sets the flag.
- R8: `done` is 1 for exactly the one cycle after each `smp_vld`, and `status` already shows the new pass in that cycle. `done` is 0 in every other cycle.
- R9: A synchronous active-high `rst` clears all run counters, all flags, the status word and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe: a new set of samples is present |
| va | input | SW | Phase A magnitude sample |
| vb | input | SW | Phase B magnitude sample |
| vc | input | SW | Phase C magnitude sample |
| thr | input | SW | Sag threshold shared by all phases |
| sag_len | input | CW | Number of consecutive low samples that sets a flag (0 acts as 1) |
| f0_lvl | input | 1 | Fundamental-frequency square-wave level |
| status | output | 32 | Packed status word for the last completed pass |
| done | output | 1 | One-cycle pulse: the status word has been refreshed |

## Verification
Every result of a pass is due one clock after the strobe: the updated flags, the F0 bit and the done pulse all appear together in that cycle. The bench drives each strobe for a single cycle starting on a falling edge. It compares `done` and the whole status word against its model at the next falling edge. One cycle later it checks that `done` has dropped and that the word is unchanged. Samples exactly at the threshold, a zero run length, broken runs and a mid-run reset are driven directly. Random runs of samples close to the threshold cover the general case.

// File: rtl/sag_status_mon.sv
module sag_status_mon #(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [SW-1:0] va,
  input  logic [SW-1:0] vb,
  input  logic [SW-1:0] vc,
  input  logic [SW-1:0] thr,
  input  logic [CW-1:0] sag_len,
  input  logic          f0_lvl,
  output logic [31:0]   status,
  output logic          done
);
  localparam int NPH = 3;

  logic [SW-1:0] smp [NPH];
  logic [CW-1:0] cnt [NPH];
  logic [NPH-1:0] flg_n, flg_q;
  logic f0_q;
  logic [CW-1:0] lim;

  assign smp[0] = va;
  assign smp[1] = vb;
  assign smp[2] = vc;
  assign lim = (sag_len == '0) ? CW'(1) : sag_len;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic low;
    logic [CW-1:0] nxt;
    assign low = smp[g] < thr;
    assign nxt = !low ? '0 : (cnt[g] >= lim) ? cnt[g] : cnt[g] + CW'(1);
    assign flg_n[g] = low && (nxt >= lim);
    always_ff @(posedge clk) begin
      if (rst) cnt[g] <= '0;
      else if (smp_vld) cnt[g] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      f0_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= smp_vld;
      if (smp_vld) begin
        flg_q <= flg_n;
        f0_q  <= f0_lvl;
      end
    end
  end

  assign status = {28'd0, f0_q, flg_q};
endmodule

module sag_status_mon_chk #(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld,
  input logic [SW-1:0] va,
  input logic [SW-1:0] thr,
  input logic [CW-1:0] sag_len,
  input logic          f0_lvl,
  input logic [31:0]   status,
  input logic          done
);
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    status[31:4] == 28'd0);
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> done);
  a_r8_done_only: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !done);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(status));
  a_r5_f0: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> status[3] == $past(f0_lvl));
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && va >= thr) |=> !status[0]);
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && va < thr && sag_len <= CW'(1)) |=> status[0]);
endmodule

bind sag_status_mon sag_status_mon_chk #(.SW(SW), .CW(CW)) u_chk (.*);

// File: tb/sag_status_mon_test.sv
module sag_status_mon_test;
  logic clk = 1'b0;
  logic rst, smp_vld, f0_lvl, done;
  logic [15:0] va, vb, vc, thr, sag_len;
  logic [31:0] status;

  int checks = 0, errors = 0;
  int m_cnt [3];
  bit m_flg [3];
  bit m_f0;

  always #2 clk = ~clk;

  sag_status_mon uut (.clk, .rst, .smp_vld, .va, .vb, .vc, .thr, .sag_len,
                      .f0_lvl, .status, .done);

  function automatic logic [31:0] exp_word();
    return {28'd0, m_f0, m_flg[2], m_flg[1], m_flg[0]};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_flg[i] = 0; end
    m_f0 = 0;
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1; smp_vld = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    model_reset();
    chk("R9 status", status, 32'd0);
    chk("R9 done", {31'd0, done}, 32'd0);
  endtask

  task automatic do_smp(logic [15:0] a, logic [15:0] b, logic [15:0] c,
                        logic f, string rq);
    logic [15:0] v [3];
    int lim;
    v[0] = a; v[1] = b; v[2] = c;
    lim = (sag_len == 0) ? 1 : int'(sag_len);
    @(negedge clk);
    va = a; vb = b; vc = c; f0_lvl = f; smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
    for (int i = 0; i < 3; i++) begin
      if (v[i] < thr) begin
        if (m_cnt[i] < lim) m_cnt[i]++;
        m_flg[i] = (m_cnt[i] >= lim);
      end else begin
        m_cnt[i] = 0; m_flg[i] = 0;
      end
    end
    m_f0 = f;
    chk({rq, " R8 done"}, {31'd0, done}, 32'd1);
    chk({rq, " R4 word"}, status, exp_word());
    f0_lvl = ~f;
    @(negedge clk);
    chk("R8 done drop", {31'd0, done}, 32'd0);
    chk("R6 hold", status, exp_word());
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; smp_vld = 0; va = 0; vb = 0; vc = 0; f0_lvl = 0;
    thr = 16'd1000; sag_len = 16'd3;
    do_rst();

    do_smp(10, 2000, 2000, 0, "R1");
    do_smp(10, 2000, 2000, 1, "R1");
    chk("R1 not early", {31'd0, status[0]}, 32'd0);
    do_smp(10, 2000, 2000, 0, "R1");
    chk("R1 set", {31'd0, status[0]}, 32'd1);
    do_smp(10, 2000, 2000, 1, "R1 sat");
    do_smp(1000, 2000, 2000, 1, "R2 equal");
    chk("R2 equal clears", {31'd0, status[0]}, 32'd0);
    do_smp(999, 999, 2000, 0, "R3");
    do_smp(999, 999, 2000, 0, "R3");
    do_smp(999, 1000, 2000, 0, "R3 break");
    do_smp(999, 5, 2000, 0, "R3");
    chk("R3 A set, B restarted", status, 32'h1);
    do_smp(999, 5, 2000, 1, "R3");
    chk("R3 B needs fresh run", {31'd0, status[1]}, 32'd0);
    do_smp(999, 5, 2000, 0, "R3");
    chk("R3 B set", status, 32'h3);

    sag_len = 0;
    do_smp(2000, 2000, 0, 1, "R7");
    chk("R7 single low sets C", status, 32'hC | exp_word());

    do_smp(0, 0, 0, 1, "R5");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    chk("R9 mid-run reset", status, 32'd0);

    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        thr = 16'($urandom_range(100, 60000));
        sag_len = 16'($urandom_range(0, 5));
      end
      do_smp(16'(int'(thr) + $urandom_range(0, 3) - 2),
             16'(int'(thr) + $urandom_range(0, 3) - 2),
             16'(int'(thr) + $urandom_range(0, 2) - 2),
             1'($urandom_range(0, 1)), "R1 R2 R3 R4 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule